// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a compact in-order processor datapath for a 32-bit integer instruction subset. Each instruction passes through five stages: fetch, decode with register read, execute or address generation, memory access, and register writeback. Every stage is a fixed register transfer. Fetch latches the instruction word and the incremented program counter. Decode latches two register operands and a sign-extended immediate. Execute latches an ALU result and a zero flag. The memory stage latches load data. Instruction storage and data storage are two separate word arrays, so an instruction fetch and a data access never compete for a port.

The pipeline does not forward results between stages. When an instruction in decode needs a register that an older instruction in execute or memory will still write, decode and fetch hold and a bubble enters execute. The register file performs its write before its reads within a cycle, so an instruction that reaches decode while its producer is in writeback proceeds without waiting. Branches test a register for zero and are resolved in the memory stage. When a branch is taken, the three younger instructions are discarded.

Before releasing reset, an integrator fills both memories through a word-wide load port. A halt instruction stops fetching, and the `halted` flag rises once the halt has retired. The result can then be inspected through a combinational register-file read port.

Top module: `pipe5_core`

## Requirements
- R1: While reset is asserted and after it is released, the program counter is 0, every pipeline stage holds a bubble, `halted` is low and every register reads 0 on the debug port.
- R2: Instruction fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0] and immediate [15:0]. Opcode 0x00 with funct 0x20/0x22/0x24/0x25/0x2A writes rs+rt, rs-rt, rs AND rt, rs OR rt, or signed (rs<rt) to rd.
- R3: Opcode 0x08 writes rs plus the sign-extended immediate to rt.
- R4: Opcode 0x23 (load) and 0x2B (store) use the byte address rs + sign-extended immediate and select data word address[9:2]. A store writes rt to that word. A load writes that word to rt. A load issued after a store sees the stored value.
- R5: Opcode 0x04 is taken when rs equals 0. Its target is branch address + 4 + (immediate << 2). The decision is made in the memory stage and the three instructions fetched after the branch are discarded. A branch that is not taken costs no cycles.
- R6: When an instruction in decode reads a register (rs for every class that uses it, rt for register-register ops and stores) that an older instruction in execute or memory will write, decode and fetch hold and a bubble enters execute. Adjacent dependent instructions lose 2 cycles. Dependent instructions one apart lose 1 cycle.
- R7: A register written back in a cycle is read by a decode in that same cycle, so a dependence two instructions apart costs no cycles.
- R8: Register 0 reads as 0 and writes to it are discarded.
- R9: Opcode 0x3F halts. No instruction after it is executed. Without stalls or taken branches, with the halt at word index n, `halted` is first high after rising edge n+5 counted from reset release. It then stays high.
- R10: With `ld_we` high, `ld_data` is written at the next rising edge into word `ld_addr` of data memory when `ld_sel_data` is 1, or of instruction memory when it is 0.
- R11: An unrecognised opcode or funct retires as a no-op and writes no register.
- R12: `dbg_data` shows the register selected by `dbg_addr` with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_we | input | 1 | Write one word through the load port |
| ld_sel_data | input | 1 | Load target: 1 data memory, 0 instruction memory |
| ld_addr | input | 8 | Word index for the load port (log2 of MEM_WORDS) |
| ld_data | input | 32 | Word to load |
| dbg_addr | input | 5 | Register number for the debug read |
| dbg_data | output | 32 | Contents of the selected register |
| halted | output | 1 | High once a halt instruction has retired |

## Verification
The assertions assume three things: the load port is idle while the pipeline runs, every fetch and data address falls inside the memory arrays, and branch targets stay word-aligned. The stimulus fills both memories only while reset is held. Its programs keep every address and branch target inside the first 64 instruction words and the 256 data words. Each program is followed by a halt, so the retirement timing and the final register contents can be checked on the debug port.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

    localparam int XLEN  = 32;
    localparam int RIDXW = 5;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_BRZ   = 6'h04;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;
    localparam logic [5:0] OP_HALT  = 6'h3F;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    // K_NOP must stay zero: an all-zero stage register is a bubble
    typedef enum logic [2:0] {
        K_NOP, K_ALU_R, K_ALU_I, K_LOAD, K_STORE, K_BRZ, K_HALT
    } kind_e;

    typedef enum logic [2:0] {
        A_ADD, A_SUB, A_AND, A_OR, A_SLT
    } aop_e;

    typedef struct packed {
        kind_e            kind;
        aop_e             aop;
        logic [RIDXW-1:0] dest;
        logic             use_rs;
        logic             use_rt;
    } dec_t;

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] ir;
        logic [XLEN-1:0] npc;
    } ifid_t;

    typedef struct packed {
        kind_e            kind;
        aop_e             aop;
        logic [RIDXW-1:0] dest;
        logic [XLEN-1:0]  a;
        logic [XLEN-1:0]  b;
        logic [XLEN-1:0]  imm;
        logic [XLEN-1:0]  npc;
    } idex_t;

    typedef struct packed {
        kind_e            kind;
        logic [RIDXW-1:0] dest;
        logic [XLEN-1:0]  alu_out;
        logic [XLEN-1:0]  b;
        logic             cond;
    } exmem_t;

    typedef struct packed {
        kind_e            kind;
        logic [RIDXW-1:0] dest;
        logic [XLEN-1:0]  alu_out;
        logic [XLEN-1:0]  lmd;
    } memwb_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        ifid_t           ifid;
        idex_t           idex;
        exmem_t          exmem;
        memwb_t          memwb;
        logic            halted;
    } core_st_t;

    function automatic dec_t decode(input logic [5:0] op, input logic [5:0] fn,
                                    input logic [RIDXW-1:0] rt, input logic [RIDXW-1:0] rd);
        dec_t d;
        d = '0;
        case (op)
            OP_RTYPE: begin
                d.dest   = rd;
                d.use_rs = 1'b1;
                d.use_rt = 1'b1;
                d.kind   = K_ALU_R;
                case (fn)
                    FN_ADD:  d.aop = A_ADD;
                    FN_SUB:  d.aop = A_SUB;
                    FN_AND:  d.aop = A_AND;
                    FN_OR:   d.aop = A_OR;
                    FN_SLT:  d.aop = A_SLT;
                    default: d = '0;
                endcase
            end
            OP_ADDI: begin
                d.kind   = K_ALU_I;
                d.aop    = A_ADD;
                d.dest   = rt;
                d.use_rs = 1'b1;
            end
            OP_LOAD: begin
                d.kind   = K_LOAD;
                d.dest   = rt;
                d.use_rs = 1'b1;
            end
            OP_STORE: begin
                d.kind   = K_STORE;
                d.use_rs = 1'b1;
                d.use_rt = 1'b1;
            end
            OP_BRZ: begin
                d.kind   = K_BRZ;
                d.use_rs = 1'b1;
            end
            OP_HALT: d.kind = K_HALT;
            default: d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pipe5_ram.sv
module pipe5_ram #(
    parameter int WORDS = 256,
    parameter int WIDTH = 32,
    localparam int IDXW = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             ld_we,
    input  logic [IDXW-1:0]  ld_idx,
    input  logic [WIDTH-1:0] ld_data,
    input  logic             st_we,
    input  logic [IDXW-1:0]  st_idx,
    input  logic [WIDTH-1:0] st_data,
    input  logic [IDXW-1:0]  rd_idx,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (ld_we) begin
            mem_q[ld_idx] <= ld_data;
        end else if (st_we) begin
            mem_q[st_idx] <= st_data;
        end
    end

    assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
    parameter int NREG  = 32,
    parameter int WIDTH = 32,
    localparam int AW = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    ra_a,
    input  logic [AW-1:0]    ra_b,
    output logic [WIDTH-1:0] rd_a,
    output logic [WIDTH-1:0] rd_b,
    input  logic             we,
    input  logic [AW-1:0]    wa,
    input  logic [WIDTH-1:0] wd,
    input  logic [AW-1:0]    dbg_a,
    output logic [WIDTH-1:0] dbg_d
);

    logic [WIDTH-1:0] rf_q [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) rf_q[i] <= '0;
        end else if (we && wa != '0) begin
            rf_q[wa] <= wd;
        end
    end

    // write-before-read: a same-cycle writeback is passed to decode
    function automatic logic [WIDTH-1:0] rd_port(input logic [AW-1:0] a);
        if (a == '0)            return '0;
        else if (we && wa == a) return wd;
        else                    return rf_q[a];
    endfunction

    assign rd_a  = rd_port(ra_a);
    assign rd_b  = rd_port(ra_b);
    assign dbg_d = (dbg_a == '0) ? '0 : rf_q[dbg_a];

    assert_wb_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wa != '0) |=> rf_q[$past(wa)] == $past(wd));

    assert_zero_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wa == '0 && ra_a == '0) |-> rd_a == '0);

endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
    import pipe5_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  aop_e             op,
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    output logic [WIDTH-1:0] res
);

    always_comb begin
        case (op)
            A_ADD:   res = x + y;
            A_SUB:   res = x - y;
            A_AND:   res = x & y;
            A_OR:    res = x | y;
            A_SLT:   res = {{(WIDTH-1){1'b0}}, ($signed(x) < $signed(y))};
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/pipe5_hazard.sv
module pipe5_hazard #(
    parameter int RW = 5
) (
    input  logic          id_valid,
    input  logic          use_rs,
    input  logic          use_rt,
    input  logic [RW-1:0] rs,
    input  logic [RW-1:0] rt,
    input  logic [RW-1:0] ex_dest,
    input  logic [RW-1:0] mem_dest,
    output logic          stall
);

    logic rs_hit, rt_hit;

    // destinations are zero for instructions that write nothing
    always_comb begin
        rs_hit = use_rs && rs != '0 && (rs == ex_dest || rs == mem_dest);
        rt_hit = use_rt && rt != '0 && (rt == ex_dest || rt == mem_dest);
        stall  = id_valid && (rs_hit || rt_hit);
    end

    always_comb begin
        assert_stall_needs_src_R6: assert (!stall || use_rs || use_rt);
    end

endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter int MEM_WORDS = 256,
    parameter int NREG      = 32,
    localparam int IDXW = $clog2(MEM_WORDS),
    localparam int RAW_ = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_we,
    input  logic             ld_sel_data,
    input  logic [IDXW-1:0]  ld_addr,
    input  logic [XLEN-1:0]  ld_data,
    input  logic [RAW_-1:0]  dbg_addr,
    output logic [XLEN-1:0]  dbg_data,
    output logic             halted
);

    core_st_t st_q, st_d;

    logic [XLEN-1:0] instr_w, ld_word_w, rs_val_w, rs_b_w, alu_y_w, alu_res_w;
    logic [XLEN-1:0] imm_w, wb_data_w;
    logic            stall_w, redirect_w, fetch_block_w, wb_we_w, st_we_w;
    dec_t            dec_w;

    // ---------------- memories ----------------
    pipe5_ram #(.WORDS(MEM_WORDS), .WIDTH(XLEN)) u_imem (
        .clk     (clk),
        .ld_we   (ld_we && !ld_sel_data),
        .ld_idx  (ld_addr),
        .ld_data (ld_data),
        .st_we   (1'b0),
        .st_idx  ('0),
        .st_data ('0),
        .rd_idx  (st_q.pc[IDXW+1:2]),
        .rd_data (instr_w)
    );

    assign st_we_w = (st_q.exmem.kind == K_STORE);

    pipe5_ram #(.WORDS(MEM_WORDS), .WIDTH(XLEN)) u_dmem (
        .clk     (clk),
        .ld_we   (ld_we && ld_sel_data),
        .ld_idx  (ld_addr),
        .ld_data (ld_data),
        .st_we   (st_we_w),
        .st_idx  (st_q.exmem.alu_out[IDXW+1:2]),
        .st_data (st_q.exmem.b),
        .rd_idx  (st_q.exmem.alu_out[IDXW+1:2]),
        .rd_data (ld_word_w)
    );

    // ---------------- register file and writeback ----------------
    always_comb begin
        wb_we_w   = (st_q.memwb.kind == K_ALU_R) || (st_q.memwb.kind == K_ALU_I) ||
                    (st_q.memwb.kind == K_LOAD);
        wb_data_w = (st_q.memwb.kind == K_LOAD) ? st_q.memwb.lmd : st_q.memwb.alu_out;
    end

    pipe5_regfile #(.NREG(NREG), .WIDTH(XLEN)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra_a  (st_q.ifid.ir[25:21]),
        .ra_b  (st_q.ifid.ir[20:16]),
        .rd_a  (rs_val_w),
        .rd_b  (rs_b_w),
        .we    (wb_we_w),
        .wa    (st_q.memwb.dest),
        .wd    (wb_data_w),
        .dbg_a (dbg_addr),
        .dbg_d (dbg_data)
    );

    // ---------------- decode and interlock ----------------
    always_comb begin
        if (st_q.ifid.valid) begin
            dec_w = decode(st_q.ifid.ir[31:26], st_q.ifid.ir[5:0],
                           st_q.ifid.ir[20:16], st_q.ifid.ir[15:11]);
        end else begin
            dec_w = '0;
        end
        imm_w = {{(XLEN-16){st_q.ifid.ir[15]}}, st_q.ifid.ir[15:0]};
    end

    pipe5_hazard #(.RW(RAW_)) u_haz (
        .id_valid (st_q.ifid.valid),
        .use_rs   (dec_w.use_rs),
        .use_rt   (dec_w.use_rt),
        .rs       (st_q.ifid.ir[25:21]),
        .rt       (st_q.ifid.ir[20:16]),
        .ex_dest  (st_q.idex.dest),
        .mem_dest (st_q.exmem.dest),
        .stall    (stall_w)
    );

    // ---------------- execute ----------------
    assign alu_y_w = (st_q.idex.kind == K_ALU_R) ? st_q.idex.b : st_q.idex.imm;

    pipe5_alu #(.WIDTH(XLEN)) u_alu (
        .op  (st_q.idex.aop),
        .x   (st_q.idex.a),
        .y   (alu_y_w),
        .res (alu_res_w)
    );

    // ---------------- next-state ----------------
    always_comb begin
        redirect_w    = (st_q.exmem.kind == K_BRZ) && st_q.exmem.cond;
        fetch_block_w = st_q.halted || (dec_w.kind == K_HALT) ||
                        (st_q.idex.kind == K_HALT) || (st_q.exmem.kind == K_HALT) ||
                        (st_q.memwb.kind == K_HALT);

        st_d = st_q;

        // writeback stage register
        st_d.memwb.kind    = st_q.exmem.kind;
        st_d.memwb.dest    = st_q.exmem.dest;
        st_d.memwb.alu_out = st_q.exmem.alu_out;
        st_d.memwb.lmd     = (st_q.exmem.kind == K_LOAD) ? ld_word_w : '0;
        st_d.halted        = st_q.halted || (st_q.memwb.kind == K_HALT);

        // memory stage register
        st_d.exmem.kind = st_q.idex.kind;
        st_d.exmem.dest = st_q.idex.dest;
        st_d.exmem.b    = st_q.idex.b;
        if (st_q.idex.kind == K_BRZ) begin
            st_d.exmem.alu_out = st_q.idex.npc + (st_q.idex.imm << 2);
            st_d.exmem.cond    = (st_q.idex.a == '0);
        end else begin
            st_d.exmem.alu_out = alu_res_w;
            st_d.exmem.cond    = 1'b0;
        end

        // execute stage register
        st_d.idex.kind = dec_w.kind;
        st_d.idex.aop  = dec_w.aop;
        st_d.idex.dest = dec_w.dest;
        st_d.idex.a    = rs_val_w;
        st_d.idex.b    = rs_b_w;
        st_d.idex.imm  = imm_w;
        st_d.idex.npc  = st_q.ifid.npc;

        if (redirect_w) begin
            st_d.exmem = '0;
            st_d.idex  = '0;
            st_d.ifid  = '0;
            st_d.pc    = st_q.exmem.alu_out;
        end else if (stall_w) begin
            st_d.idex = '0;
            st_d.ifid = st_q.ifid;
            st_d.pc   = st_q.pc;
        end else if (fetch_block_w) begin
            st_d.ifid = '0;
            st_d.pc   = st_q.pc;
        end else begin
            st_d.ifid.valid = 1'b1;
            st_d.ifid.ir    = instr_w;
            st_d.ifid.npc   = st_q.pc + XLEN'(4);
            st_d.pc         = st_q.pc + XLEN'(4);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign halted = st_q.halted;

    // ---------------- assertions ----------------
    assert_stall_holds_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_w && !redirect_w) |=> $stable(st_q.pc) && st_q.ifid == $past(st_q.ifid));

    assert_stall_bubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_w && !redirect_w) |=> st_q.idex.kind == K_NOP);

    assert_taken_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_w |=> st_q.pc == $past(st_q.exmem.alu_out) && !st_q.ifid.valid &&
                       st_q.idex.kind == K_NOP && st_q.exmem.kind == K_NOP);

    assert_pc_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pc[1:0] == 2'b00);

    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    assert_nothing_after_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> st_q.memwb.kind == K_NOP);

endmodule

// File: tb/pipe5_core_test.sv
`timescale 1ns/1ps
module pipe5_core_test;

    localparam int MW   = 256;
    localparam int AW   = $clog2(MW);
    localparam int PLEN = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_we = 1'b0;
    logic          ld_sel_data = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [31:0]   ld_data = '0;
    logic [4:0]    dbg_addr = '0;
    logic [31:0]   dbg_data;
    logic          halted;

    int n_checks = 0;
    int n_fails  = 0;

    pipe5_core #(.MEM_WORDS(MW)) uut (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_sel_data(ld_sel_data),
        .ld_addr(ld_addr), .ld_data(ld_data), .dbg_addr(dbg_addr),
        .dbg_data(dbg_data), .halted(halted)
    );

    always #2 clk = ~clk;

    // ---------------- scoreboard ----------------
    typedef struct {
        int          r;
        logic [31:0] v;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    logic drain_req = 1'b0;
    logic drain_ack = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic expect_reg(input int r, input logic [31:0] v, input string tag);
        exp_t e;
        e.r = r; e.v = v; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // monitor: pops expected register values and compares via debug port
    initial begin
        forever begin
            wait (drain_req);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                dbg_addr = 5'(e.r);
                #1;
                chk(dbg_data === e.v, e.tag, dbg_data, e.v);
            end
            drain_ack = 1'b1;
            wait (!drain_req);
            drain_ack = 1'b0;
        end
    end

    // ---------------- encoders ----------------
    function automatic logic [31:0] rr(input logic [5:0] fn, input int rd, input int rs, input int rt);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] ii(input logic [5:0] op, input int rt, input int rs, input int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    localparam logic [31:0] NOP_W  = 32'h0000_0000;
    localparam logic [31:0] HALT_W = 32'hFC00_0000;

    logic [31:0] prog [PLEN];

    task automatic clear_prog();
        for (int i = 0; i < PLEN; i++) prog[i] = NOP_W;
    endtask

    task automatic load_word(input bit to_data, input int idx, input logic [31:0] w);
        @(negedge clk);
        ld_we = 1'b1; ld_sel_data = to_data; ld_addr = AW'(idx); ld_data = w;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    // reset, load program, run until halted, check retirement cycle, drain scoreboard
    task automatic run_prog(input string name, input int exp_cyc);
        int cyc;
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < PLEN; i++) load_word(1'b0, i, prog[i]);
        @(negedge clk);
        dbg_addr = 5'd4;
        #1;
        chk(halted === 1'b0, {name, " R1 halted low in reset"}, 32'(halted), 32'h0);
        chk(dbg_data === 32'h0, {name, " R1 register cleared by reset"}, dbg_data, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;
        while (halted !== 1'b1 && cyc < 400) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
        chk(cyc == exp_cyc, {name, " R9 halt retirement cycle"}, 32'(cyc), 32'(exp_cyc));
        repeat (3) @(negedge clk);
        chk(halted === 1'b1, {name, " R9 halted stays high"}, 32'(halted), 32'h1);
        drain_req = 1'b1;
        wait (drain_ack);
        drain_req = 1'b0;
        wait (!drain_ack);
    endtask

    initial begin
        #(50000 * 4);
        n_fails++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);

        // ---- program A: ALU ops, immediates, r0, unknown opcode, no stalls ----
        clear_prog();
        prog[0]  = ii(6'h08, 1, 0, 7);
        prog[1]  = ii(6'h08, 2, 0, -3);
        prog[2]  = ii(6'h08, 3, 0, 100);
        prog[3]  = ii(6'h08, 0, 0, 55);
        prog[4]  = ii(6'h3E, 10, 0, 9);
        prog[5]  = rr(6'h20, 4, 1, 2);
        prog[6]  = rr(6'h22, 5, 1, 2);
        prog[7]  = rr(6'h24, 6, 1, 2);
        prog[8]  = rr(6'h25, 7, 1, 2);
        prog[9]  = rr(6'h2A, 8, 2, 1);
        prog[10] = rr(6'h2A, 9, 1, 2);
        prog[11] = HALT_W;
        expect_reg(1, 32'd7,         "R3 addi positive");
        expect_reg(2, 32'hFFFF_FFFD, "R3 addi sign-extended");
        expect_reg(3, 32'd100,       "R3 addi third");
        expect_reg(0, 32'h0,         "R8 write to r0 discarded");
        expect_reg(10, 32'h0,        "R11 unknown opcode no write");
        expect_reg(4, 32'd4,         "R2 add");
        expect_reg(5, 32'd10,        "R2 sub");
        expect_reg(6, 32'd5,         "R2 and");
        expect_reg(7, 32'hFFFF_FFFF, "R2 or");
        expect_reg(8, 32'd1,         "R2 slt true signed");
        expect_reg(9, 32'd0,         "R2 slt false");
        expect_reg(12, 32'h0,        "R12 untouched register reads zero");
        run_prog("progA", 16);

        // ---- program B: RAW interlock distances 1, 2, 3 ----
        clear_prog();
        prog[0] = ii(6'h08, 1, 0, 5);
        prog[1] = ii(6'h08, 2, 1, 1);
        prog[2] = NOP_W;
        prog[3] = ii(6'h08, 3, 2, 1);
        prog[4] = ii(6'h08, 9, 0, 1);
        prog[5] = ii(6'h08, 8, 0, 2);
        prog[6] = ii(6'h08, 4, 3, 1);
        prog[7] = HALT_W;
        expect_reg(2, 32'd6, "R6 adjacent dependence value");
        expect_reg(3, 32'd7, "R6 one-apart dependence value");
        expect_reg(4, 32'd8, "R7 two-apart dependence value");
        // 7 + 5 + 2 (adjacent) + 1 (one apart) + 0 (two apart, R7)
        run_prog("progB R6 R7", 15);

        // ---- program C: loads, stores, halt squashing ----
        clear_prog();
        load_word(1'b1, 32, 32'h1234_5678);
        load_word(1'b1, 15, 32'hCAFE_F00D);
        prog[0]  = ii(6'h08, 1, 0, 64);
        prog[1]  = ii(6'h08, 2, 0, 32'h77);
        prog[2]  = NOP_W;
        prog[3]  = NOP_W;
        prog[4]  = ii(6'h2B, 2, 1, 8);
        prog[5]  = ii(6'h23, 3, 1, 64);
        prog[6]  = ii(6'h23, 4, 1, 8);
        prog[7]  = ii(6'h23, 5, 1, -4);
        prog[8]  = rr(6'h20, 6, 4, 3);
        prog[9]  = HALT_W;
        prog[10] = ii(6'h08, 7, 0, 9);
        prog[11] = ii(6'h08, 8, 0, 9);
        expect_reg(3, 32'h1234_5678, "R10 preloaded data word via load");
        expect_reg(4, 32'h0000_0077, "R4 store then load");
        expect_reg(5, 32'hCAFE_F00D, "R4 negative offset load");
        expect_reg(6, 32'h1234_56EF, "R4 load result feeds add");
        expect_reg(7, 32'h0,         "R9 after halt not executed");
        expect_reg(8, 32'h0,         "R9 second after halt not executed");
        run_prog("progC R4", 15);

        // ---- program D: untaken and taken branches, wrong-path halt ----
        clear_prog();
        prog[0]  = ii(6'h08, 1, 0, 3);
        prog[1]  = NOP_W;
        prog[2]  = NOP_W;
        prog[3]  = ii(6'h04, 0, 1, 5);
        prog[4]  = ii(6'h08, 2, 0, 11);
        prog[5]  = ii(6'h04, 0, 0, 4);
        prog[6]  = HALT_W;
        prog[7]  = ii(6'h08, 4, 0, 1);
        prog[8]  = ii(6'h08, 5, 0, 1);
        prog[9]  = ii(6'h08, 7, 0, 1);
        prog[10] = ii(6'h08, 6, 0, 22);
        prog[11] = HALT_W;
        expect_reg(2, 32'd11, "R5 untaken branch falls through");
        expect_reg(4, 32'h0,  "R5 flushed slot two");
        expect_reg(5, 32'h0,  "R5 flushed slot three");
        expect_reg(7, 32'h0,  "R5 skipped word");
        expect_reg(6, 32'd22, "R5 branch target executed");
        // target idx 10 fetched at edge 10, halt idx 11 at edge 11, retired after edge 15
        run_prog("progD R5", 15);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule